// File: doc/BRIEF.md
# Monotonic-Switching SAR Conversion Sequencer

This block is the digital sequencer of a fully differential successive-approximation converter whose capacitor arrays switch monotonically. While idle it leaves the sample/hold open so the arrays track the input. A rising edge of the external sample clock closes the sample/hold. The block then waits until the internal conversion oscillator reports ready, and resolves the code from the most significant bit downward, one comparator decision per bit.

No trial bit is driven. The first decision is taken on the raw held differential input. After every later decision except the last, exactly one capacitor switches: the largest one not yet switched, on the side that the comparison found higher. The other side is left untouched. Each decision is paced by a request/valid handshake with the comparator, so the length of a conversion follows the comparator and not a fixed count. When the last bit is known, the code is registered with a one-cycle strobe, all switch controls are cleared and tracking resumes. The same logic serves slow (hundreds of samples per second) and fast (ten thousand per second) sample clocks, because nothing in it depends on how long tracking lasts.

All inputs except the sample clock are taken as synchronous to `clk`. The sample clock passes through a synchronizer before its rising edge is detected.

Top module: `mono_sar_seq`

## Requirements
- R1: While `rst` is high at a clock edge, in the following cycle `hold_en`, `cmp_req`, `code_vld`, `overrun` and every bit of `sw_pos`/`sw_neg` are 0.
- R2: A rising edge on `smp_clk` seen while tracking sets `hold_en` to 1 within a few cycles, set by the synchronizer depth. A falling edge, or a steady level, leaves `hold_en` at 0.
- R3: While holding, `cmp_req` stays 0 until `clkgen_rdy` is seen high.
- R4: Once raised, `cmp_req` stays high until `cmp_valid` is seen high, and drops in the next cycle. It is not raised again until `cmp_valid` has been seen low. Each conversion issues exactly NBITS requests.
- R5: The first decision of a conversion is requested with every switch control at 0.
- R6: Switch index i (0 = smallest, NBITS-2 = largest) belongs to decision NBITS-2-i. When that decision returns `cmp_pos_gt`=1, `sw_pos[i]` is set, and when it returns 0, `sw_neg[i]` is set. No other control changes, the last decision sets nothing, and `sw_pos[i]` and `sw_neg[i]` are never both 1. At the last request, `sw_pos[i]` equals code bit i+1 and `sw_neg[i]` equals its inverse.
- R7: Code bit NBITS-1-k holds the value of `cmp_pos_gt` at decision k (k=0 first). `code` is updated together with `code_vld`, which is high for exactly one cycle per conversion.
- R8: In the cycle in which `code_vld` is high, `hold_en` is 0 and all switch controls are 0.
- R9: A rising edge on `smp_clk` while a conversion is in progress starts nothing and sets `overrun`. `overrun` stays set until `rst`.
- R10: A conversion takes as long as the comparator handshakes require, with no fixed budget, and the result is the same for any tracking length and any comparator latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high; returns the block to tracking |
| smp_clk | input | 1 | External sample clock, asynchronous; its rising edge starts a conversion |
| clkgen_rdy | input | 1 | Internal conversion oscillator is stable |
| cmp_valid | input | 1 | Comparator decision available |
| cmp_pos_gt | input | 1 | Comparator decision: 1 when the positive node is above the negative node |
| hold_en | output | 1 | 1 = sample/hold in hold, 0 = tracking |
| cmp_req | output | 1 | Comparator evaluate request |
| sw_pos | output | NBITS-1 | Positive-array switch controls, bit NBITS-2 is the largest capacitor |
| sw_neg | output | NBITS-1 | Negative-array switch controls, same indexing |
| code | output | NBITS | Registered conversion result, MSB first decided |
| code_vld | output | 1 | One-cycle strobe accompanying a new `code` |
| overrun | output | 1 | Sticky: a sample edge arrived during a conversion |

## Verification
The comparator is modelled from the switch outputs themselves. A target code X gives a starting residual of 2X-(2^NBITS-1). Each asserted `sw_pos[i]` takes 2^(i+1) off the residual and each `sw_neg[i]` adds it, so a wrong index, a wrong side or a missing switch all turn up as a wrong final code. The sweep covers codes in steps of three across the 11-bit range, plus the extreme and mid-scale codes where the MSB decision flips. Comparator latency is randomized so that no step relies on a fixed delay. Separate runs use a long tracking interval, a delayed oscillator-ready with a sample edge during the wait (overrun), a falling sample edge alone, and a slow comparator whose longer conversion must still give the same code.

// File: rtl/mono_sar_pkg.sv
package mono_sar_pkg;

  typedef enum logic [2:0] {
    ST_TRACK,
    ST_WAIT_RDY,
    ST_ASK,
    ST_SETTLE,
    ST_FINISH
  } sar_state_e;

  // Decision step that switches capacitor index cap (largest cap = nbits-2).
  function automatic int step_for_cap(input int cap, input int nbits);
    return nbits - 2 - cap;
  endfunction

  // Decision step that resolves result bit b.
  function automatic int step_for_bit(input int b, input int nbits);
    return nbits - 1 - b;
  endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  // chain[STAGES-1] is the last synchronizer stage, chain[STAGES] its delayed copy
  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sar_step_fsm.sv
module sar_step_fsm
  import mono_sar_pkg::*;
#(
  parameter int NBITS  = 11,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rdy_i,
  input  logic              cmp_valid_i,
  output logic              cmp_req_o,
  output logic              hold_o,
  output logic [STEP_W-1:0] step_o,
  output logic              decide_o,
  output logic              finish_o,
  output logic              overrun_o,
  output logic              in_wait_o,
  output logic              first_step_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NBITS - 1);

  sar_state_e        state;
  logic [STEP_W-1:0] step;
  logic              overrun_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_TRACK;
      step      <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (start_i && state != ST_TRACK) overrun_q <= 1'b1;
      unique case (state)
        ST_TRACK: if (start_i) begin
          state <= ST_WAIT_RDY;
          step  <= '0;
        end
        ST_WAIT_RDY: if (rdy_i) state <= ST_ASK;
        ST_ASK:      if (cmp_valid_i) state <= ST_SETTLE;
        ST_SETTLE:   if (!cmp_valid_i) begin
          if (step == LAST_STEP) state <= ST_FINISH;
          else begin
            step  <= step + 1'b1;
            state <= ST_ASK;
          end
        end
        ST_FINISH:   state <= ST_TRACK;
        default:     state <= ST_TRACK;
      endcase
    end
  end

  assign cmp_req_o    = (state == ST_ASK);
  assign hold_o       = (state != ST_TRACK);
  assign decide_o     = (state == ST_ASK) && cmp_valid_i;
  assign finish_o     = (state == ST_FINISH);
  assign in_wait_o    = (state == ST_WAIT_RDY);
  assign first_step_o = (step == '0);
  assign step_o       = step;
  assign overrun_o    = overrun_q;
endmodule

// File: rtl/sar_cap_switch.sv
module sar_cap_switch
  import mono_sar_pkg::*;
#(
  parameter int NBITS  = 11,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              decide_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              pos_gt_i,
  output logic [NBITS-2:0]  sw_pos_o,
  output logic [NBITS-2:0]  sw_neg_o
);
  localparam int NCAP = NBITS - 1;

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    localparam logic [STEP_W-1:0] MY_STEP = STEP_W'(step_for_cap(i, NBITS));
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        sw_pos_o[i] <= 1'b0;
        sw_neg_o[i] <= 1'b0;
      end else if (decide_i && step_i == MY_STEP) begin
        // the higher side drops its largest unswitched capacitor
        sw_pos_o[i] <= pos_gt_i;
        sw_neg_o[i] <= ~pos_gt_i;
      end
    end
  end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg
  import mono_sar_pkg::*;
#(
  parameter int NBITS  = 11,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decide_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              pos_gt_i,
  input  logic              finish_i,
  output logic [NBITS-1:0]  code_o,
  output logic              code_vld_o
);
  logic [NBITS-1:0] work;

  always_ff @(posedge clk) begin
    if (rst) begin
      work       <= '0;
      code_o     <= '0;
      code_vld_o <= 1'b0;
    end else begin
      for (int b = 0; b < NBITS; b++) begin
        if (decide_i && step_i == STEP_W'(step_for_bit(b, NBITS))) work[b] <= pos_gt_i;
      end
      if (finish_i) code_o <= work;
      code_vld_o <= finish_i;
    end
  end
endmodule

// File: rtl/mono_sar_seq.sv
module mono_sar_seq #(
  parameter int NBITS       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_clk,
  input  logic             clkgen_rdy,
  input  logic             cmp_valid,
  input  logic             cmp_pos_gt,
  output logic             hold_en,
  output logic             cmp_req,
  output logic [NBITS-2:0] sw_pos,
  output logic [NBITS-2:0] sw_neg,
  output logic [NBITS-1:0] code,
  output logic             code_vld,
  output logic             overrun
);
  localparam int STEP_W = $clog2(NBITS);

  logic              start_edge;
  logic [STEP_W-1:0] step;
  logic              decide;
  logic              finish;
  logic              in_wait;
  logic              first_step;

  sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(smp_clk), .rise_o(start_edge)
  );

  sar_step_fsm #(.NBITS(NBITS), .STEP_W(STEP_W)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_edge), .rdy_i(clkgen_rdy),
    .cmp_valid_i(cmp_valid), .cmp_req_o(cmp_req), .hold_o(hold_en),
    .step_o(step), .decide_o(decide), .finish_o(finish),
    .overrun_o(overrun), .in_wait_o(in_wait), .first_step_o(first_step)
  );

  sar_cap_switch #(.NBITS(NBITS), .STEP_W(STEP_W)) u_sw (
    .clk(clk), .rst(rst), .clear_i(finish), .decide_i(decide),
    .step_i(step), .pos_gt_i(cmp_pos_gt), .sw_pos_o(sw_pos), .sw_neg_o(sw_neg)
  );

  sar_result_reg #(.NBITS(NBITS), .STEP_W(STEP_W)) u_res (
    .clk(clk), .rst(rst), .decide_i(decide), .step_i(step),
    .pos_gt_i(cmp_pos_gt), .finish_i(finish), .code_o(code), .code_vld_o(code_vld)
  );
endmodule

// File: rtl/mono_sar_seq_chk.sv
module mono_sar_seq_chk #(
  parameter int NBITS = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             clkgen_rdy,
  input logic             cmp_valid,
  input logic             hold_en,
  input logic             cmp_req,
  input logic [NBITS-2:0] sw_pos,
  input logic [NBITS-2:0] sw_neg,
  input logic             code_vld,
  input logic             overrun,
  input logic             in_wait,
  input logic             first_step
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!hold_en && !cmp_req && !code_vld && !overrun && sw_pos == '0 && sw_neg == '0));

  // R3
  wait_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !clkgen_rdy) |=> !cmp_req);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_req && !cmp_valid) |=> cmp_req);

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_req && cmp_valid) |=> !cmp_req);

  // R4
  req_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmp_req && cmp_valid) |=> !cmp_req);

  // R5
  first_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmp_req) && first_step) |-> (sw_pos == '0 && sw_neg == '0));

  // R6
  side_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_pos & sw_neg) == '0);

  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones({sw_pos, sw_neg}) == 0) ||
    ($countones({sw_pos, sw_neg}) <= $countones($past({sw_pos, sw_neg})) + 1));

  // R6
  no_partial_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(sw_pos) & ~sw_pos) != '0 || ($past(sw_neg) & ~sw_neg) != '0)
      |-> (sw_pos == '0 && sw_neg == '0));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld |=> !code_vld);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> (!hold_en && sw_pos == '0 && sw_neg == '0));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind mono_sar_seq mono_sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .clkgen_rdy(clkgen_rdy), .cmp_valid(cmp_valid),
  .hold_en(hold_en), .cmp_req(cmp_req), .sw_pos(sw_pos), .sw_neg(sw_neg),
  .code_vld(code_vld), .overrun(overrun), .in_wait(in_wait), .first_step(first_step)
);

// File: tb/mono_sar_seq_tb.sv
module mono_sar_seq_tb_top;
  localparam int NB = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_clk = 1'b0;
  logic          clkgen_rdy = 1'b0;
  logic          cmp_valid = 1'b0;
  logic          cmp_pos_gt = 1'b0;
  logic          hold_en, cmp_req, code_vld, overrun;
  logic [NB-2:0] sw_pos, sw_neg;
  logic [NB-1:0] code;

  int checks = 0;
  int errors = 0;
  int target = 0;
  int req_cnt = 0;
  int cmp_max = 2;
  int last_conv_cycles = 0;

  always #10 clk = ~clk;

  mono_sar_seq dut_i (
    .clk(clk), .rst(rst), .smp_clk(smp_clk), .clkgen_rdy(clkgen_rdy),
    .cmp_valid(cmp_valid), .cmp_pos_gt(cmp_pos_gt), .hold_en(hold_en),
    .cmp_req(cmp_req), .sw_pos(sw_pos), .sw_neg(sw_neg), .code(code),
    .code_vld(code_vld), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // residual seen by an ideal comparator, rebuilt from the switch outputs
  function automatic int residual(input int x, input logic [NB-2:0] sp, input logic [NB-2:0] sn);
    int r = 2 * x - ((1 << NB) - 1);
    for (int i = 0; i < NB - 1; i++) begin
      if (sp[i]) r -= (1 << (i + 1));
      if (sn[i]) r += (1 << (i + 1));
    end
    return r;
  endfunction

  // comparator model with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (cmp_req && !cmp_valid) begin
        if (req_cnt == 0)
          chk(sw_pos == '0 && sw_neg == '0, "R5 first decision unswitched", int'({sw_pos, sw_neg}), 0);
        else
          chk($countones({sw_pos, sw_neg}) == req_cnt, "R6 one switch per step",
              $countones({sw_pos, sw_neg}), req_cnt);
        if (req_cnt == NB - 1) begin
          chk(int'(sw_pos) == (target >> 1), "R6 final positive pattern", int'(sw_pos), target >> 1);
          chk(int'(sw_neg) == ((~target >> 1) & ((1 << (NB - 1)) - 1)), "R6 final negative pattern",
              int'(sw_neg), (~target >> 1) & ((1 << (NB - 1)) - 1));
        end
        req_cnt++;
        repeat ($urandom_range(0, cmp_max)) @(negedge clk);
        cmp_pos_gt = residual(target, sw_pos, sw_neg) > 0;
        cmp_valid  = 1'b1;
      end else if (!cmp_req && cmp_valid) begin
        repeat ($urandom_range(0, cmp_max)) @(negedge clk);
        cmp_valid = 1'b0;
      end
    end
  end

  task automatic convert(input int x, input int rdy_wait, input bit pulse_mid, input int track);
    int n;
    bit early;
    target  = x;
    req_cnt = 0;
    @(negedge clk);
    smp_clk = 1'b1;
    n = 0;
    while (!hold_en && n < 20) begin @(negedge clk); n++; end
    chk(hold_en == 1'b1, "R2 rising sample edge holds", hold_en, 1);
    early = 1'b0;
    for (int c = 0; c < rdy_wait; c++) begin
      if (pulse_mid && c == 1) smp_clk = 1'b0;
      if (pulse_mid && c == 5) smp_clk = 1'b1;
      @(negedge clk);
      if (cmp_req) early = 1'b1;
    end
    if (rdy_wait > 0) chk(!early, "R3 no request before ready", early, 0);
    clkgen_rdy = 1'b1;
    n = 0;
    while (!code_vld && n < 2000) begin @(negedge clk); n++; end
    last_conv_cycles = n;
    chk(code_vld == 1'b1, "R7 strobe seen", code_vld, 1);
    chk(int'(code) == x, "R7 code value", int'(code), x);
    chk(!hold_en && sw_pos == '0 && sw_neg == '0, "R8 released at done",
        int'({hold_en, sw_pos, sw_neg}), 0);
    chk(req_cnt == NB, "R4 request count", req_cnt, NB);
    @(negedge clk);
    chk(code_vld == 1'b0, "R7 one-cycle strobe", code_vld, 0);
    clkgen_rdy = 1'b0;
    smp_clk = 1'b0;
    early = 1'b0;
    for (int c = 0; c < track; c++) begin
      @(negedge clk);
      if (hold_en) early = 1'b1;
    end
    chk(!early, "R2 falling edge and level ignored", early, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fast_cycles;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!hold_en && !cmp_req && !code_vld && !overrun && sw_pos == '0 && sw_neg == '0 && code == '0,
        "R1 reset state", int'({hold_en, cmp_req, code_vld, overrun}), 0);

    // corners around full scale and mid scale
    convert(0, 0, 1'b0, 6);
    convert((1 << NB) - 1, 0, 1'b0, 6);
    convert(1 << (NB - 1), 2, 1'b0, 6);
    convert((1 << (NB - 1)) - 1, 0, 1'b0, 6);
    convert(1, 0, 1'b0, 6);
    convert((1 << NB) - 2, 0, 1'b0, 6);

    // near-exhaustive sweep
    for (int x = 0; x < (1 << NB); x += 3) convert(x, x % 4, 1'b0, 6);

    // R10: long tracking, then fast vs slow comparator on one code
    cmp_max = 0;
    convert(1365, 0, 1'b0, 2000);
    fast_cycles = last_conv_cycles;
    cmp_max = 6;
    convert(1365, 0, 1'b0, 6);
    chk(last_conv_cycles > fast_cycles, "R10 conversion length follows comparator",
        last_conv_cycles, fast_cycles + 1);
    cmp_max = 2;

    // R9: sample edge during the ready wait
    chk(overrun == 1'b0, "R9 no overrun before", overrun, 0);
    convert(777, 12, 1'b1, 8);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    convert(300, 0, 1'b0, 6);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

    // R1: synchronous reset from a hold
    @(negedge clk);
    smp_clk = 1'b1;
    repeat (6) @(negedge clk);
    chk(hold_en == 1'b1, "R2 holding before reset", hold_en, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!hold_en && !overrun && sw_pos == '0 && sw_neg == '0, "R1 reset returns to tracking",
        int'({hold_en, overrun}), 0);
    smp_clk = 1'b0;
    repeat (4) @(negedge clk);
    convert(1024, 0, 1'b0, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule